// File: doc/BRIEF.md
# Command Block Window and Index Queues

This block holds a small array of command control blocks and the two index queues that carry them between a host and a sequencer. The host picks one block with a pointer register and reaches its bytes one at a time through a byte window. An offset register places the window inside the block. Its auto-advance bit lets the host stream a whole block, normally the 26 meaningful bytes of a 32-byte slot, as back-to-back window accesses.

To start a command, the host writes the block index into an input queue. The sequencer takes indices from the head of that queue through a pop port. When the sequencer finishes a block, it pushes the index into an output queue. The host drains that queue by reading it while its count is nonzero. The command-complete interrupt stays high while the output queue holds anything.

The sequencer also has a read-only byte port into the block array. Both queue counts can be read. A sticky status register records a push that was lost because a queue was full. The host can put a command at the head of the input queue: it reads every waiting index out, writes the new index, then writes the saved indices back.

Top module: `cbq_top`

## Requirements
- R1: After reset the pointer, the offset, the auto-advance bit, both queue counts, the status register and `cmd_irq` are all zero.
- R2: The host register map is selected by `host_addr`. 0 is the pointer, 1 is the offset, 2 is the window, 3 is the input queue, 4 is the input count, 5 is the output queue, 6 is the output count and 7 is the status. A pointer write keeps only the low log2(NUM_BLOCKS) bits, and those bits read back. The window reads and writes byte `offset` of the block that the pointer selects.
- R3: In the offset register, bit 7 enables auto-advance and bits 4:0 hold the byte offset. Bits 6:5 read as zero. With auto-advance set, every window read or write adds one to the offset, and the offset wraps from 31 to 0.
- R4: With auto-advance clear, the offset stays fixed across any number of window reads and writes.
- R5: A host write to address 3 pushes the index held in the low bits of the data. The sequencer sees the oldest index on `seq_in_idx`, with `seq_in_valid` high. A pop, from `seq_in_pop` or from a host read of address 3, removes that index. Address 4 reads the number of indices waiting.
- R6: A `seq_out_push` pulse pushes `seq_out_idx` into the output queue. Host reads of address 5 return the indices in push order, and address 6 reads the number waiting.
- R7: Reading address 3 or address 5 while that queue is empty returns 0xFF and leaves its count at zero.
- R8: Each queue holds 16 indices. A push into a full queue is dropped, and the count does not change. It sets a sticky status bit: bit 0 for the input queue, bit 1 for the output queue. Writing 1 to a status bit clears it.
- R9: `cmd_irq` is high exactly while the output count is nonzero. It rises only after a sequencer push, and it falls only after a host read of the output queue.
- R10: If the host reads every waiting input index, writes a new one, and then writes the saved indices back, the sequencer receives the new index first and the old ones after it, in their original order.
- R11: `seq_rdata` always shows byte `seq_byte` of block `seq_blk`, as the host last wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects at the clock edge) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| seq_blk | input | IW | Sequencer block select for the byte read port |
| seq_byte | input | OW | Sequencer byte select |
| seq_rdata | output | 8 | Sequencer read data |
| seq_in_pop | input | 1 | Sequencer takes the head of the input queue |
| seq_in_valid | output | 1 | Input queue is non-empty |
| seq_in_idx | output | IW | Head of the input queue |
| seq_out_push | input | 1 | Completion pulse, pushes `seq_out_idx` |
| seq_out_idx | input | IW | Index of the finished block |
| cmd_irq | output | 1 | Command-complete interrupt |

## Verification
The assertions check three things on every cycle. First, the window offset steps by exactly one, with wrap, on an auto-advance access, and it holds still otherwise. Second, a queue's count never passes its depth, is unchanged by a dropped push, and does not underflow on a pop when empty. Third, the interrupt changes only after a sequencer push or a host drain. Only the bench scenarios can show that data moves correctly. Those scenarios cover the full block array written and read back through the window and the sequencer port, first-in first-out order through both queues, head requeueing, and the 0xFF value returned by an empty read.

// File: rtl/cbq_pkg.sv
package cbq_pkg;

  typedef enum logic [2:0] {
    REG_PTR     = 3'd0,
    REG_OFS     = 3'd1,
    REG_WIN     = 3'd2,
    REG_QIN     = 3'd3,
    REG_QINCNT  = 3'd4,
    REG_QOUT    = 3'd5,
    REG_QOUTCNT = 3'd6,
    REG_STAT    = 3'd7
  } reg_sel_e;

  localparam logic [7:0] EMPTY_READ = 8'hFF;
  localparam int unsigned AUTO_BIT  = 7;
  localparam int unsigned OFS_BITS  = 5;

  // Offset after one window access.
  function automatic logic [OFS_BITS-1:0] step_offset(
      input logic [OFS_BITS-1:0] ofs, input logic auto_en);
    return auto_en ? ofs + 1'b1 : ofs;
  endfunction

  // Byte image of the offset register.
  function automatic logic [7:0] ofs_image(
      input logic auto_en, input logic [OFS_BITS-1:0] ofs);
    return {auto_en, 2'b00, ofs};
  endfunction

endpackage

// File: rtl/cbq_index_fifo.sv
module cbq_index_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             ovf_clr,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             ovf
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    rd_p, wr_p;
  logic [CW-1:0]    cnt_q;
  logic             ovf_q;

  // Named events for the checks below.
  logic do_push, do_pop, drop_push;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == DEPTH_C);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign drop_push = push && full;

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_p] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p  <= '0;
      wr_p  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_p <= wrap_inc(wr_p);
      if (do_pop)  rd_p <= wrap_inc(rd_p);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (drop_push)    ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign head  = slots[rd_p];
  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_push && !pop) |=> (count == $past(count)) && ovf);

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/cbq_block_store.sv
module cbq_block_store #(
  parameter int unsigned NUM_BLOCKS  = 16,
  parameter int unsigned BLOCK_BYTES = 32,
  localparam int unsigned IW = $clog2(NUM_BLOCKS),
  localparam int unsigned OW = $clog2(BLOCK_BYTES),
  localparam int unsigned AW = IW + OW,
  localparam int unsigned SIZE = NUM_BLOCKS * BLOCK_BYTES
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] w_blk,
  input  logic [OW-1:0] w_byte,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] a_blk,
  input  logic [OW-1:0] a_byte,
  output logic [7:0]    a_data,
  input  logic [IW-1:0] b_blk,
  input  logic [OW-1:0] b_byte,
  output logic [7:0]    b_data
);

  logic [7:0] bytes_q [SIZE];

  function automatic logic [AW-1:0] flat(input logic [IW-1:0] blk,
                                         input logic [OW-1:0] byt);
    return {blk, byt};
  endfunction

  always_ff @(posedge clk) begin
    if (we) bytes_q[flat(w_blk, w_byte)] <= wdata;
  end

  assign a_data = bytes_q[flat(a_blk, a_byte)];
  assign b_data = bytes_q[flat(b_blk, b_byte)];

endmodule

// File: rtl/cbq_top.sv
module cbq_top
  import cbq_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS  = 16,
  parameter int unsigned BLOCK_BYTES = 32,
  parameter int unsigned QDEPTH      = 16,
  localparam int unsigned IW = $clog2(NUM_BLOCKS),
  localparam int unsigned OW = $clog2(BLOCK_BYTES),
  localparam int unsigned CW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic [IW-1:0] seq_blk,
  input  logic [OW-1:0] seq_byte,
  output logic [7:0]    seq_rdata,
  input  logic          seq_in_pop,
  output logic          seq_in_valid,
  output logic [IW-1:0] seq_in_idx,
  input  logic          seq_out_push,
  input  logic [IW-1:0] seq_out_idx,
  output logic          cmd_irq
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(host_addr);

  // Decoded host events, named for the checks.
  logic win_access, win_wr, ofs_wr, ptr_wr;
  logic qin_push, qin_pop, qout_pop;
  logic [1:0] stat_clr;
  assign win_access = (host_rd || host_wr) && (sel == REG_WIN);
  assign win_wr     = host_wr && (sel == REG_WIN);
  assign ofs_wr     = host_wr && (sel == REG_OFS);
  assign ptr_wr     = host_wr && (sel == REG_PTR);
  assign qin_push   = host_wr && (sel == REG_QIN);
  assign qin_pop    = (host_rd && (sel == REG_QIN)) || seq_in_pop;
  assign qout_pop   = host_rd && (sel == REG_QOUT);
  assign stat_clr   = (host_wr && (sel == REG_STAT)) ? host_wdata[1:0] : 2'b00;

  logic [IW-1:0]       ptr_q;
  logic [OFS_BITS-1:0] ofs_q;
  logic                auto_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ofs_q  <= '0;
      auto_q <= 1'b0;
    end else begin
      if (ptr_wr) ptr_q <= host_wdata[IW-1:0];
      if (ofs_wr) begin
        ofs_q  <= host_wdata[OFS_BITS-1:0];
        auto_q <= host_wdata[AUTO_BIT];
      end else if (win_access) begin
        ofs_q <= step_offset(ofs_q, auto_q);
      end
    end
  end

  logic [7:0] win_data;

  cbq_block_store #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) store_i (
    .clk   (clk),
    .we    (win_wr),
    .w_blk (ptr_q),
    .w_byte(ofs_q[OW-1:0]),
    .wdata (host_wdata),
    .a_blk (ptr_q),
    .a_byte(ofs_q[OW-1:0]),
    .a_data(win_data),
    .b_blk (seq_blk),
    .b_byte(seq_byte),
    .b_data(seq_rdata)
  );

  logic [IW-1:0] qin_head, qout_head;
  logic [CW-1:0] qin_cnt, qout_cnt;
  logic          qin_empty, qout_empty, qin_full, qout_full;
  logic          qin_ovf, qout_ovf;

  cbq_index_fifo #(.DEPTH(QDEPTH), .WIDTH(IW)) qin_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (qin_push),
    .push_data(host_wdata[IW-1:0]),
    .pop      (qin_pop),
    .ovf_clr  (stat_clr[0]),
    .head     (qin_head),
    .count    (qin_cnt),
    .empty    (qin_empty),
    .full     (qin_full),
    .ovf      (qin_ovf)
  );

  cbq_index_fifo #(.DEPTH(QDEPTH), .WIDTH(IW)) qout_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (seq_out_push),
    .push_data(seq_out_idx),
    .pop      (qout_pop),
    .ovf_clr  (stat_clr[1]),
    .head     (qout_head),
    .count    (qout_cnt),
    .empty    (qout_empty),
    .full     (qout_full),
    .ovf      (qout_ovf)
  );

  assign seq_in_valid = !qin_empty;
  assign seq_in_idx   = qin_head;
  assign cmd_irq      = !qout_empty;

  always_comb begin
    host_rdata = '0;
    case (sel)
      REG_PTR:     host_rdata = {{(8-IW){1'b0}}, ptr_q};
      REG_OFS:     host_rdata = ofs_image(auto_q, ofs_q);
      REG_WIN:     host_rdata = win_data;
      REG_QIN:     host_rdata = qin_empty ? EMPTY_READ : {{(8-IW){1'b0}}, qin_head};
      REG_QINCNT:  host_rdata = {{(8-CW){1'b0}}, qin_cnt};
      REG_QOUT:    host_rdata = qout_empty ? EMPTY_READ : {{(8-IW){1'b0}}, qout_head};
      REG_QOUTCNT: host_rdata = {{(8-CW){1'b0}}, qout_cnt};
      REG_STAT:    host_rdata = {6'b0, qout_ovf, qin_ovf};
      default:     host_rdata = '0;
    endcase
  end

  // R3
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_access && auto_q) |=> (ofs_q == $past(ofs_q) + 1'b1));

  // R4
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_access && !auto_q) |=> $stable(ofs_q));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_irq) |-> $past(seq_out_push));

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_irq) |-> $past(qout_pop));

  // R8
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qin_full && qin_push && !qin_pop) |=> qin_ovf);

endmodule

// File: tb/cbq_top_tb_top.sv
module cbq_top_tb_top;

  localparam int NB = 16;
  localparam int USED = 26;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [3:0] seq_blk = '0;
  logic [4:0] seq_byte = '0;
  logic [7:0] seq_rdata;
  logic       seq_in_pop = 1'b0, seq_in_valid;
  logic [3:0] seq_in_idx;
  logic       seq_out_push = 1'b0;
  logic [3:0] seq_out_idx = '0;
  logic       cmd_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cbq_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .seq_blk(seq_blk), .seq_byte(seq_byte), .seq_rdata(seq_rdata),
    .seq_in_pop(seq_in_pop), .seq_in_valid(seq_in_valid), .seq_in_idx(seq_in_idx),
    .seq_out_push(seq_out_push), .seq_out_idx(seq_out_idx), .cmd_irq(cmd_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'((b * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic spush(input logic [3:0] v);
    @(negedge clk);
    seq_out_idx = v; seq_out_push = 1'b1;
    @(negedge clk);
    seq_out_push = 1'b0;
  endtask

  task automatic spop(input string req, input logic [3:0] exp);
    @(negedge clk);
    #1 chk(req, {3'b0, seq_in_valid, seq_in_idx}, {4'b0001, exp});
    seq_in_pop = 1'b1;
    @(negedge clk);
    seq_in_pop = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hrd(3'd0, d); chk("R1 ptr", d, 8'h00);
    hrd(3'd1, d); chk("R1 ofs", d, 8'h00);
    hrd(3'd4, d); chk("R1 in count", d, 8'h00);
    hrd(3'd6, d); chk("R1 out count", d, 8'h00);
    hrd(3'd7, d); chk("R1 status", d, 8'h00);
    #1 chk("R1 irq", {7'b0, cmd_irq}, 8'h00);

    // R2 pointer masking and offset image (R3)
    hwr(3'd0, 8'hF3); hrd(3'd0, d); chk("R2 ptr mask", d, 8'h03);
    hwr(3'd1, 8'hFF); hrd(3'd1, d); chk("R3 ofs image", d, 8'h9F);

    // R2 R3 stream every block in with auto-advance, then back out
    for (int b = 0; b < NB; b++) begin
      hwr(3'd0, 8'(b)); hwr(3'd1, 8'h80);
      for (int i = 0; i < USED; i++) hwr(3'd2, pat(b, i));
      hrd(3'd1, d); chk("R3 offset after stream", d, 8'h80 | 8'(USED));
    end
    for (int b = NB - 1; b >= 0; b--) begin
      hwr(3'd0, 8'(b)); hwr(3'd1, 8'h80);
      for (int i = 0; i < USED; i++) begin
        hrd(3'd2, d); chk("R2 window readback", d, pat(b, i));
      end
    end
    // R11 sequencer port sweep
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < USED; i += 5) begin
        @(negedge clk); seq_blk = 4'(b); seq_byte = 5'(i);
        #1 chk("R11 seq read", seq_rdata, pat(b, i));
      end
    end

    // R3 wrap 31 -> 0
    hwr(3'd0, 8'h03); hwr(3'd1, 8'h9F); hwr(3'd2, 8'hAB);
    hrd(3'd1, d); chk("R3 wrap", d, 8'h80);
    @(negedge clk); seq_blk = 4'd3; seq_byte = 5'd31;
    #1 chk("R11 byte 31", seq_rdata, 8'hAB);

    // R4 fixed offset
    hwr(3'd0, 8'h07); hwr(3'd1, 8'h05);
    hwr(3'd2, 8'h11); hwr(3'd2, 8'h22);
    hrd(3'd1, d); chk("R4 ofs after writes", d, 8'h05);
    hrd(3'd2, d); chk("R4 last write", d, 8'h22);
    hrd(3'd2, d); chk("R4 repeat read", d, 8'h22);
    hrd(3'd1, d); chk("R4 ofs after reads", d, 8'h05);
    @(negedge clk); seq_blk = 4'd7; seq_byte = 5'd6;
    #1 chk("R4 neighbour untouched", seq_rdata, pat(7, 6));

    // R5 R8 fill input queue past full
    for (int k = 0; k < 16; k++) hwr(3'd3, 8'(15 - k));
    hrd(3'd4, d); chk("R5 in count full", d, 8'd16);
    hrd(3'd7, d); chk("R8 no overflow yet", d, 8'h00);
    for (int k = 0; k < 3; k++) hwr(3'd3, 8'h05);
    hrd(3'd4, d); chk("R8 in count after drop", d, 8'd16);
    hrd(3'd7, d); chk("R8 in overflow", d, 8'h01);
    for (int k = 0; k < 16; k++) spop("R5 seq order", 4'(15 - k));
    #1 chk("R5 valid low", {7'b0, seq_in_valid}, 8'h00);
    // R7 empty read
    hrd(3'd3, d); chk("R7 empty in read", d, 8'hFF);
    hrd(3'd4, d); chk("R7 in count stays 0", d, 8'h00);
    hwr(3'd7, 8'h01); hrd(3'd7, d); chk("R8 clear", d, 8'h00);

    // R10 head requeue
    hwr(3'd3, 8'd3); hwr(3'd3, 8'd7); hwr(3'd3, 8'd9);
    hrd(3'd4, d); chk("R5 count 3", d, 8'd3);
    hrd(3'd3, d); chk("R10 save a", d, 8'd3);
    hrd(3'd3, d); chk("R10 save b", d, 8'd7);
    hrd(3'd3, d); chk("R10 save c", d, 8'd9);
    hwr(3'd3, 8'd12); hwr(3'd3, 8'd3); hwr(3'd3, 8'd7); hwr(3'd3, 8'd9);
    spop("R10 new first", 4'd12);
    spop("R10 old a", 4'd3);
    spop("R10 old b", 4'd7);
    spop("R10 old c", 4'd9);

    // R6 R9 output queue
    spush(4'd2); spush(4'd11); spush(4'd6);
    #1 chk("R9 irq high", {7'b0, cmd_irq}, 8'h01);
    hrd(3'd6, d); chk("R6 out count", d, 8'd3);
    begin
      logic [3:0] expq [3];
      int n;
      expq[0] = 4'd2; expq[1] = 4'd11; expq[2] = 4'd6;
      n = 0;
      hrd(3'd6, d);
      while (d != 0 && n < 8) begin
        logic [7:0] v;
        hrd(3'd5, v);
        if (n < 3) chk("R6 drain order", v, {4'b0, expq[n]});
        n++;
        hrd(3'd6, d);
      end
      chk("R6 drained count", 8'(n), 8'd3);
    end
    #1 chk("R9 irq low", {7'b0, cmd_irq}, 8'h00);

    // R8 output overflow, R7 empty output read
    for (int k = 0; k < 17; k++) spush(4'(k));
    hrd(3'd6, d); chk("R8 out count", d, 8'd16);
    hrd(3'd7, d); chk("R8 out overflow", d, 8'h02);
    for (int k = 0; k < 16; k++) begin
      hrd(3'd5, d); chk("R6 long drain", d, 8'(k));
    end
    hrd(3'd5, d); chk("R7 empty out read", d, 8'hFF);
    hrd(3'd6, d); chk("R7 out count stays 0", d, 8'h00);
    hwr(3'd7, 8'h02); hrd(3'd7, d); chk("R8 out clear", d, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule